// File: doc/BRIEF.md
# Serial EEPROM Emulator

This block is a SPI slave that answers like a small serial EEPROM. A host drives `sclk`, `cs_n` and `mosi` in SPI mode 0 and reads `miso`. Each transaction opens with a one-byte command. Data commands are then followed by an address of `ADDR_BYTES` bytes, sent most significant byte first. The block holds an internal byte array and a status register. After each accepted program operation it models the device's busy time with a counter that runs for a fixed number of clock cycles.

The SPI pins are sampled by the system clock through a three-stage synchronizer, so the SPI clock must run well below `clk`. Programming is gated by a write-enable latch. Writes land only when chip select is released, and a write wraps its address inside the current page. Reads stream data for as long as chip select stays low.

Top module: `eeprom_emu`

## Requirements
- R1: Command 0x06 sets the write-enable latch and command 0x04 clears it. Status bit 1 shows the latch.
- R2: Command 0x05 returns the status byte repeatedly until chip select rises. The status byte is laid out as follows: bit 7 is the protect-enable flag, bits 6:4 read 0, bits 3:2 are the two block-protect bits, bit 1 is the write-enable latch and bit 0 is busy.
- R3: Command 0x01 takes no address. The first data byte supplies bits 7, 3 and 2, which are stored when chip select rises, and its other bits are ignored.
- R4: Command 0x03 is followed by the address. Address bits above the array width are ignored. The block then returns bytes from consecutive addresses, MSB first, and wraps from the top of the array back to 0.
- R5: Command 0x02 is followed by the address and then data bytes, which go to consecutive addresses inside one page of `PAGE_BYTES`. Bytes past the end of the page wrap to the start of that page, and a later byte replaces an earlier byte at the same spot. Only complete bytes count, and they are committed when chip select rises.
- R6: A 0x02 or 0x01 command issued while the write-enable latch is clear changes nothing.
- R7: An accepted 0x02 or 0x01 command clears the write-enable latch when chip select rises.
- R8: A commit sets busy for `BUSY_CYCLES` clock cycles. A 0x02 or 0x01 command issued while busy changes nothing and leaves the latch as it was.
- R9: After reset, the status byte reads 0x00, every array byte reads 0xFF and `miso` is 0.
- R10: The block samples `mosi` on rising `sclk` and changes `miso` after falling `sclk`, MSB first. `miso` stays 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, samples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | Active-low chip select, frames one command |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
The bench aims at the following corner cases:
- A page write that starts two bytes before a page boundary, and one that sends more bytes than a page holds. A design that carried into the next page would corrupt its neighbour instead of wrapping.
- A read that crosses the top of the array. A wrong wrap would return 0xFF instead of the bytes at low addresses.
- Program commands sent without the latch, or sent while busy. These must leave both the array and the latch unchanged.
- A frame that ends in the middle of a byte, which must not commit that partial byte.
- A status write, which must keep only the three stored bits.

// File: rtl/eeprom_emu_pkg.sv
package eeprom_emu_pkg;

  localparam logic [7:0] OPC_WEN_SET = 8'h06;
  localparam logic [7:0] OPC_WEN_CLR = 8'h04;
  localparam logic [7:0] OPC_SR_RD   = 8'h05;
  localparam logic [7:0] OPC_SR_WR   = 8'h01;
  localparam logic [7:0] OPC_DATA_RD = 8'h03;
  localparam logic [7:0] OPC_DATA_WR = 8'h02;

  // next address of a sequential read: wraps at the array top
  function automatic int unsigned seq_next(int unsigned a, int unsigned size);
    return (a + 1) % size;
  endfunction

  // next address of a page write: stays inside the page of a
  function automatic int unsigned page_next(int unsigned a, int unsigned page);
    return (a / page) * page + ((a + 1) % page);
  endfunction

  // fold a received address onto the array
  function automatic int unsigned addr_cut(int unsigned a, int unsigned size);
    return a % size;
  endfunction

  function automatic logic [7:0] make_status(logic wpen, logic [1:0] bp,
                                             logic wel, logic busy);
    return {wpen, 3'b000, bp, wel, busy};
  endfunction

endpackage

// File: rtl/eeprom_spi_link.sv
module eeprom_spi_link (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic [7:0] tx_byte,
  output logic       miso,
  output logic       frame_start,
  output logic       frame_end,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  logic [2:0] sclk_s, cs_s, mosi_s;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;
  logic       tx_pend;
  logic       active, sclk_rise, sclk_fall, mosi_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= 3'b000;
      cs_s   <= 3'b111;
      mosi_s <= 3'b000;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      cs_s   <= {cs_s[1:0], cs_n};
      mosi_s <= {mosi_s[1:0], mosi};
    end
  end

  assign active      = ~cs_s[1];
  assign frame_start = ~cs_s[1] &  cs_s[2];
  assign frame_end   =  cs_s[1] & ~cs_s[2];
  assign sclk_rise   =  sclk_s[1] & ~sclk_s[2];
  assign sclk_fall   = ~sclk_s[1] &  sclk_s[2];
  assign mosi_bit    = mosi_s[1];
  assign byte_done   = active & sclk_rise & (bit_cnt == 3'd7);
  assign rx_byte     = {rx_sh, mosi_bit};
  assign miso        = active & tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= 3'd0;
      rx_sh   <= 7'd0;
      tx_sh   <= 8'd0;
      tx_pend <= 1'b0;
    end else if (frame_start) begin
      bit_cnt <= 3'd0;
      tx_sh   <= 8'd0;
      tx_pend <= 1'b0;
    end else if (active && sclk_rise) begin
      rx_sh   <= {rx_sh[5:0], mosi_bit};
      bit_cnt <= bit_cnt + 3'd1;
      if (bit_cnt == 3'd7) tx_pend <= 1'b1;
    end else if (active && sclk_fall) begin
      if (tx_pend) begin
        tx_sh   <= tx_byte;
        tx_pend <= 1'b0;
      end else begin
        tx_sh <= {tx_sh[6:0], 1'b0};
      end
    end
  end

  AST_BYTE_ARMS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (bit_cnt == 3'd0) && tx_pend); // R10

endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(MEM_BYTES)-1:0] rd_addr,
  output logic [7:0]                rd_data,
  input  logic                      commit,
  input  logic [$clog2(MEM_BYTES)-1:0] page_base,
  input  logic [PAGE_BYTES*8-1:0]   page_data,
  input  logic [PAGE_BYTES-1:0]     page_valid
);
  localparam int AW = $clog2(MEM_BYTES);

  logic [7:0] mem [MEM_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (page_valid[i]) mem[page_base | AW'(i)] <= page_data[i*8 +: 8];
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_emu_pkg::*;
#(
  parameter int ADDR_BYTES  = 2,
  parameter int MEM_BYTES   = 256,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_start,
  input  logic                    frame_end,
  input  logic                    byte_done,
  input  logic [7:0]              rx_byte,
  output logic [7:0]              tx_byte,
  output logic [$clog2(MEM_BYTES)-1:0] rd_addr,
  input  logic [7:0]              rd_data,
  output logic                    commit,
  output logic [$clog2(MEM_BYTES)-1:0] page_base,
  output logic [PAGE_BYTES*8-1:0] page_data,
  output logic [PAGE_BYTES-1:0]   page_valid
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [2:0] IDX_LAST = 3'(ADDR_BYTES);
  localparam logic [2:0] IDX_DATA = 3'(ADDR_BYTES + 1);

  logic [2:0]    idx;
  logic [7:0]    opcode;
  logic [15:0]   addr_sh;
  logic [AW-1:0] cur_addr, full_addr;
  logic          accept, sr_got, wel, wpen;
  logic [1:0]    bp;
  logic [2:0]    sr_new;
  logic [CW-1:0] busy_cnt;
  logic          busy, is_mem_op, addr_last, sr_commit, prog_end;
  logic [7:0]    status_byte;

  assign is_mem_op   = (opcode == OPC_DATA_RD) || (opcode == OPC_DATA_WR);
  assign addr_last   = byte_done && is_mem_op && (idx == IDX_LAST);
  assign full_addr   = AW'(addr_cut({8'd0, addr_sh, rx_byte}, MEM_BYTES));
  assign rd_addr     = addr_last ? full_addr : cur_addr;
  assign busy        = (busy_cnt != '0);
  assign status_byte = make_status(wpen, bp, wel, busy);
  assign prog_end    = frame_end && accept;
  assign commit      = prog_end && (opcode == OPC_DATA_WR) && (|page_valid);
  assign sr_commit   = prog_end && (opcode == OPC_SR_WR) && sr_got;
  assign page_base   = {cur_addr[AW-1:PW], {PW{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= 3'd0; opcode <= 8'd0; addr_sh <= 16'd0; cur_addr <= '0;
      accept <= 1'b0; sr_got <= 1'b0; sr_new <= 3'd0; wel <= 1'b0;
      wpen <= 1'b0; bp <= 2'b00; busy_cnt <= '0; tx_byte <= 8'd0;
      page_data <= '0; page_valid <= '0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - CW'(1);
      if (frame_start) begin
        idx <= 3'd0; opcode <= 8'd0; addr_sh <= 16'd0; accept <= 1'b0;
        sr_got <= 1'b0; page_valid <= '0; tx_byte <= 8'd0;
      end
      if (frame_end) begin
        if (prog_end) wel <= 1'b0;
        if (commit || sr_commit) busy_cnt <= CW'(BUSY_CYCLES);
        if (sr_commit) {wpen, bp} <= sr_new;
        opcode <= 8'd0;
        accept <= 1'b0;
      end
      if (byte_done) begin
        if (idx != IDX_DATA) idx <= idx + 3'd1;
        if (idx == 3'd0) begin
          opcode <= rx_byte;
          case (rx_byte)
            OPC_WEN_SET: wel <= 1'b1;
            OPC_WEN_CLR: wel <= 1'b0;
            OPC_SR_RD:   tx_byte <= status_byte;
            OPC_SR_WR, OPC_DATA_WR: accept <= wel && !busy;
            default: ;
          endcase
        end else begin
          if (is_mem_op && idx <= IDX_LAST) addr_sh <= {addr_sh[7:0], rx_byte};
          case (opcode)
            OPC_SR_RD: tx_byte <= status_byte;
            OPC_SR_WR: if (accept && !sr_got) begin
              sr_new <= {rx_byte[7], rx_byte[3:2]};
              sr_got <= 1'b1;
            end
            OPC_DATA_RD: if (addr_last || idx == IDX_DATA) begin
              tx_byte  <= rd_data;
              cur_addr <= AW'(seq_next(32'(rd_addr), MEM_BYTES));
            end
            OPC_DATA_WR: begin
              if (addr_last) cur_addr <= full_addr;
              else if (idx == IDX_DATA && accept) begin
                page_data[cur_addr[PW-1:0]*8 +: 8] <= rx_byte;
                page_valid[cur_addr[PW-1:0]]       <= 1'b1;
                cur_addr <= AW'(page_next(32'(cur_addr), PAGE_BYTES));
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy); // R8
  AST_NO_COMMIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || sr_commit) |-> !busy); // R8
  AST_BUSY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(commit || sr_commit)) |=> busy_cnt == $past(busy_cnt) - CW'(1)); // R8
  AST_COMMIT_HAS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || sr_commit) |-> wel); // R6
  AST_WEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    prog_end |=> !wel); // R7

endmodule

// File: rtl/eeprom_emu.sv
module eeprom_emu #(
  parameter int ADDR_BYTES  = 2,
  parameter int MEM_BYTES   = 256,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  localparam int AW = $clog2(MEM_BYTES);

  logic                    frame_start, frame_end, byte_done, commit;
  logic [7:0]              rx_byte, tx_byte, rd_data;
  logic [AW-1:0]           rd_addr, page_base;
  logic [PAGE_BYTES*8-1:0] page_data;
  logic [PAGE_BYTES-1:0]   page_valid;

  eeprom_spi_link u_link (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .tx_byte(tx_byte), .miso(miso), .frame_start(frame_start),
    .frame_end(frame_end), .byte_done(byte_done), .rx_byte(rx_byte)
  );

  eeprom_ctrl #(
    .ADDR_BYTES(ADDR_BYTES), .MEM_BYTES(MEM_BYTES),
    .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .frame_end(frame_end), .byte_done(byte_done), .rx_byte(rx_byte),
    .tx_byte(tx_byte), .rd_addr(rd_addr), .rd_data(rd_data),
    .commit(commit), .page_base(page_base), .page_data(page_data),
    .page_valid(page_valid)
  );

  eeprom_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .commit(commit), .page_base(page_base), .page_data(page_data),
    .page_valid(page_valid)
  );

endmodule

// File: tb/test_eeprom_emu.sv
module test_eeprom_emu;
  localparam int MEM = 256, PAGE = 16, AB = 2, BUSY = 1000, HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  wire  miso;
  always #5 clk = ~clk;

  eeprom_emu #(.ADDR_BYTES(AB), .MEM_BYTES(MEM), .PAGE_BYTES(PAGE),
               .BUSY_CYCLES(BUSY)) i_eeprom_emu (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  int vectors = 0, miscompares = 0, hi_cnt = 0;
  bit done = 1'b0, live = 1'b0;
  logic [7:0] mdl_mem [MEM];
  bit         mdl_wel = 1'b0;
  logic [7:0] mdl_sr = 8'h00;
  logic [7:0] txq[$], rxq[$];

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(int tail_bits);
    rxq.delete();
    cs_n = 1'b0; tick(HALF);
    foreach (txq[k]) begin
      logic [7:0] r = 8'd0;
      for (int b = 7; b >= 0; b--) begin
        mosi = txq[k][b]; tick(HALF);
        r = {r[6:0], miso}; sclk = 1'b1; tick(HALF); sclk = 1'b0;
      end
      rxq.push_back(r);
    end
    for (int b = 0; b < tail_bits; b++) begin
      mosi = 1'b1; tick(HALF); sclk = 1'b1; tick(HALF); sclk = 1'b0;
    end
    tick(HALF); cs_n = 1'b1; tick(2*HALF);
  endtask

  function automatic logic [7:0] exp_status(bit busy);
    return mdl_sr | {6'd0, mdl_wel, busy};
  endfunction

  task automatic cmd(logic [7:0] op);
    txq = '{op}; frame(0);
    if (op == 8'h06) mdl_wel = 1'b1;
    if (op == 8'h04) mdl_wel = 1'b0;
  endtask

  task automatic status_rd(string req, bit busy);
    txq = '{8'h05, 8'h00, 8'h00, 8'h00}; frame(0);
    for (int k = 1; k < 4; k++) chk(req, rxq[k], exp_status(busy));
  endtask

  task automatic mem_rd(string req, int addr, int n);
    txq = '{8'h03, 8'(addr >> 8), 8'(addr)};
    for (int k = 0; k < n; k++) txq.push_back(8'h00);
    frame(0);
    for (int k = 0; k < n; k++) chk(req, rxq[3+k], mdl_mem[(addr + k) % MEM]);
  endtask

  // apply: the write is expected to be accepted
  task automatic mem_wr(int addr, logic [7:0] d[$], int tail_bits, bit apply);
    txq = '{8'h02, 8'(addr >> 8), 8'(addr)};
    foreach (d[k]) txq.push_back(d[k]);
    frame(tail_bits);
    if (apply) begin
      foreach (d[k]) begin
        int base = (addr % MEM) - ((addr % MEM) % PAGE);
        mdl_mem[base + ((addr + k) % PAGE)] = d[k];
      end
      mdl_wel = 1'b0;
    end
  endtask

  task automatic sr_wr(logic [7:0] v, bit apply);
    txq = '{8'h01, v}; frame(0);
    if (apply) begin
      mdl_sr = v & 8'h8C;
      mdl_wel = 1'b0;
    end
  endtask

  // R10: miso must be quiet while chip select is high, checked every clock
  always @(negedge clk) begin
    if (!cs_n || !rst_n) hi_cnt <= 0;
    else begin
      hi_cnt <= hi_cnt + 1;
      if (live && !done && hi_cnt >= 4) chk("R10 idle miso", miso, 0);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEM; i++) mdl_mem[i] = 8'hFF;
    tick(5); rst_n = 1'b1; tick(5); live = 1'b1;
    // R9 reset state
    chk("R9 miso", miso, 0);
    status_rd("R9 status", 1'b0);
    mem_rd("R9 array", 0, 4);
    // R6 write without latch
    mem_wr(8'h10, '{8'hAA}, 0, 1'b0);
    mem_rd("R6 ignored write", 8'h10, 1);
    // R1 latch set / clear
    cmd(8'h06); status_rd("R1 set", 1'b0);
    cmd(8'h04); status_rd("R1 clear", 1'b0);
    // R5 page wrap at boundary, R7 latch drop, R8 busy
    cmd(8'h06);
    mem_wr(8'h1E, '{8'h11, 8'h22, 8'h33}, 0, 1'b1);
    status_rd("R7 R8 busy", 1'b1);
    cmd(8'h06);
    mem_wr(8'h40, '{8'h55}, 0, 1'b0);          // R8 ignored while busy
    tick(BUSY + 200);
    status_rd("R8 idle, latch kept", 1'b0);
    mem_rd("R8 ignored write", 8'h40, 1);
    cmd(8'h04);
    mem_rd("R5 wrap in page", 8'h0E, 20);
    // R4 high address bits ignored, wrap at top
    mem_rd("R4 high bits", 16'h011E, 2);
    cmd(8'h06); mem_wr(8'hFE, '{8'h01, 8'h02}, 0, 1'b1); tick(BUSY + 200);
    cmd(8'h06); mem_wr(8'h00, '{8'hC0, 8'hC1}, 0, 1'b1); tick(BUSY + 200);
    mem_rd("R4 top wrap", 8'hFD, 6);
    // R5 overfull page and partial byte
    cmd(8'h06);
    begin
      logic [7:0] d[$];
      for (int k = 0; k < 18; k++) d.push_back(8'(8'h80 + k));
      mem_wr(8'h35, d, 0, 1'b1);
    end
    tick(BUSY + 200);
    mem_rd("R5 overfull", 8'h30, 16);
    cmd(8'h06); mem_wr(8'h50, '{8'h5A}, 4, 1'b1); tick(BUSY + 200);
    mem_rd("R5 partial byte", 8'h50, 2);
    // R3 status write, R6 without latch
    cmd(8'h06); sr_wr(8'hFF, 1'b1);
    status_rd("R3 busy", 1'b1);
    tick(BUSY + 200);
    status_rd("R3 stored bits", 1'b0);
    sr_wr(8'h00, 1'b0);
    status_rd("R6 status kept", 1'b0);
    cmd(8'h06); sr_wr(8'h00, 1'b1); tick(BUSY + 200);
    status_rd("R2 R3 cleared", 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule